// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Detector

This block turns the debounced input of one GPIO pin into interrupt and wake status. A registered copy of the pin gives the previous value. A trigger-type bit and a two-bit polarity field then pick one of several events: a rising edge, a falling edge, either edge, a high level or a low level. When the event occurs and interrupting is enabled, a sticky status bit is set. A second sticky bit records wake events. It is set only while the system reports that it is asleep and at least one sleep-level wake permission is granted.

The pin is pending when either status bit is set. Software clears both bits with a one-cycle clear strobe. The outgoing request is raised only when the pin is pending, interrupting is enabled and the unmask control is 1. With the unmask control at 0, the status still records events but no request leaves the block. A parent register block drives the control inputs. A parent aggregator collects the request.

Top module: `gpio_irq_trigger`

## Requirements
- R1: After reset, `int_sts`, `wake_sts` and `irq_req` are all 0.
- R2: With `level_mode`=0 and `polarity`=2'b00, a 0-to-1 change of `pin_in` sets `int_sts` at the first rising clock edge that samples the new value. A 1-to-0 change sets nothing.
- R3: With `level_mode`=0 and `polarity`=2'b01, only a 1-to-0 change of `pin_in` sets `int_sts`.
- R4: With `polarity`=2'b10, both kinds of change set `int_sts` in edge mode. In level mode, `polarity` 2'b10 and 2'b11 never set any status.
- R5: With `level_mode`=1, `int_sts` is set on every clock edge at which `pin_in` is at the active level: 1 for `polarity` 2'b00, 0 for 2'b01.
- R6: While `irq_en`=0, no trigger sets `int_sts`.
- R7: `irq_req` equals `irq_en` AND `irq_unmask` AND (`int_sts` OR `wake_sts`), with no clock delay. With `irq_unmask`=0, status still sets but no request is raised.
- R8: A `clr_strobe` pulse clears `int_sts` and `wake_sts` at the next clock edge. If the level trigger is still active at that edge, `int_sts` is set again.
- R9: If a clear and a new trigger event fall in the same cycle, the event wins and the status stays 1.
- R10: `wake_sts` is set by a trigger event only when `sleep_active`=1 and at least one `wake_en` bit is 1. It does not depend on `irq_en`. A set `wake_sts` alone makes the pin pending.
- R11: `int_sts` stays set after the pin leaves the active condition, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Debounced pin value |
| irq_en | input | 1 | Interrupt status generation enable |
| irq_unmask | input | 1 | 1 lets a pending pin raise a request |
| level_mode | input | 1 | 0 edge trigger, 1 level trigger |
| polarity | input | 2 | 00 high/rising, 01 low/falling, 10 both edges, 11 none |
| wake_en | input | 3 | Wake permission per sleep level (idle, suspend, hibernate) |
| sleep_active | input | 1 | System is in a sleep state |
| clr_strobe | input | 1 | Clear pulse for both status bits |
| int_sts | output | 1 | Sticky interrupt status |
| wake_sts | output | 1 | Sticky wake status |
| irq_req | output | 1 | Qualified interrupt request |

## Verification
The clear strobe and a trigger event can land in the same clock cycle. The bench provokes this in two ways. In edge mode, it drives a rising pin together with the strobe. In level mode, it pulses the strobe while the pin is held at the active level. In both cases `int_sts` must still read 1 after that edge. A strobe issued alone, one cycle later, must then bring it to 0.

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       irq_en,
  input  logic       irq_unmask,
  input  logic       level_mode,
  input  logic [1:0] polarity,
  input  logic [2:0] wake_en,
  input  logic       sleep_active,
  input  logic       clr_strobe,
  output logic       int_sts,
  output logic       wake_sts,
  output logic       irq_req
);

  logic pin_q;
  logic rise, fall, hit_edge, hit_level, trig;

  assign rise = pin_in & ~pin_q;
  assign fall = ~pin_in & pin_q;

  always_comb begin
    case (polarity)
      2'b00:   hit_edge = rise;
      2'b01:   hit_edge = fall;
      2'b10:   hit_edge = rise | fall;
      default: hit_edge = 1'b0;
    endcase
    case (polarity)
      2'b00:   hit_level = pin_in;
      2'b01:   hit_level = ~pin_in;
      default: hit_level = 1'b0;
    endcase
  end

  assign trig = level_mode ? hit_level : hit_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= 1'b0;
      int_sts  <= 1'b0;
      wake_sts <= 1'b0;
    end else begin
      pin_q <= pin_in;
      if (trig && irq_en)                          int_sts <= 1'b1;
      else if (clr_strobe)                         int_sts <= 1'b0;
      if (trig && (|wake_en) && sleep_active)      wake_sts <= 1'b1;
      else if (clr_strobe)                         wake_sts <= 1'b0;
    end
  end

  assign irq_req = irq_en & irq_unmask & (int_sts | wake_sts);

endmodule

module gpio_irq_trigger_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_in,
  input logic       irq_en,
  input logic       irq_unmask,
  input logic       level_mode,
  input logic [1:0] polarity,
  input logic [2:0] wake_en,
  input logic       sleep_active,
  input logic       clr_strobe,
  input logic       int_sts,
  input logic       wake_sts,
  input logic       irq_req
);
  a_r5_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && irq_en && polarity == 2'b00 && pin_in) |=> int_sts);
  a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_en && irq_unmask));
  a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !int_sts) |=> !int_sts);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && !irq_en && wake_en == 3'b000) |=> (!int_sts && !wake_sts));
  a_r10_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_active && !wake_sts) |=> !wake_sts);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sts && !clr_strobe) |=> int_sts);
endmodule

bind gpio_irq_trigger gpio_irq_trigger_chk i_chk (.*);

// File: tb/test_gpio_irq_trigger.sv
module test_gpio_irq_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b0, irq_en = 1'b0, irq_unmask = 1'b0, level_mode = 1'b0;
  logic [1:0] polarity = 2'b00;
  logic [2:0] wake_en = 3'b000;
  logic sleep_active = 1'b0, clr_strobe = 1'b0;
  logic int_sts, wake_sts, irq_req;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_trigger i_gpio_irq_trigger (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_strobe = 1'b1; step(); clr_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 int_sts", int_sts, 1'b0);
    chk("R1 wake_sts", wake_sts, 1'b0);
    chk("R1 irq_req", irq_req, 1'b0);
  endtask

  task automatic t_rising();
    irq_en = 1; irq_unmask = 1; level_mode = 0; polarity = 2'b00;
    pin_in = 1; step();
    chk("R2 rising sets", int_sts, 1'b1);
    chk("R7 request", irq_req, 1'b1);
    step(); step();
    chk("R11 sticky", int_sts, 1'b1);
    clear_all();
    chk("R8 clear", int_sts, 1'b0);
    pin_in = 0; step();
    chk("R2 falling ignored", int_sts, 1'b0);
  endtask

  task automatic t_falling();
    polarity = 2'b01;
    pin_in = 1; step();
    chk("R3 rising ignored", int_sts, 1'b0);
    pin_in = 0; step();
    chk("R3 falling sets", int_sts, 1'b1);
    clear_all();
  endtask

  task automatic t_both();
    polarity = 2'b10;
    pin_in = 1; step();
    chk("R4 both rise", int_sts, 1'b1);
    clear_all();
    pin_in = 0; step();
    chk("R4 both fall", int_sts, 1'b1);
    clear_all();
    level_mode = 1; pin_in = 1; step(); step();
    chk("R4 both invalid in level", int_sts, 1'b0);
    pin_in = 0; step();
    chk("R4 both invalid in level low", int_sts, 1'b0);
  endtask

  task automatic t_level();
    level_mode = 1; polarity = 2'b00;
    pin_in = 1; step();
    chk("R5 high level", int_sts, 1'b1);
    clear_all();
    chk("R8 level reasserts", int_sts, 1'b1);
    pin_in = 0; clear_all();
    chk("R8 level clear inactive", int_sts, 1'b0);
    polarity = 2'b01; step();
    chk("R5 low level", int_sts, 1'b1);
    pin_in = 1; clear_all();
    chk("R5 low level clear", int_sts, 1'b0);
  endtask

  task automatic t_disabled();
    level_mode = 0; polarity = 2'b00; irq_en = 0;
    pin_in = 0; step();
    pin_in = 1; step();
    chk("R6 no status when disabled", int_sts, 1'b0);
    chk("R6 no request", irq_req, 1'b0);
  endtask

  task automatic t_mask();
    irq_en = 1; irq_unmask = 0;
    pin_in = 0; step();
    pin_in = 1; step();
    chk("R7 masked status set", int_sts, 1'b1);
    chk("R7 masked no request", irq_req, 1'b0);
    irq_unmask = 1; #1;
    chk("R7 unmask raises request", irq_req, 1'b1);
    clear_all();
  endtask

  task automatic t_collision();
    pin_in = 0; step();
    pin_in = 1; step();
    pin_in = 0; step();
    pin_in = 1; clr_strobe = 1; step(); clr_strobe = 0;
    chk("R9 event beats clear", int_sts, 1'b1);
    clear_all();
    chk("R9 lone clear", int_sts, 1'b0);
  endtask

  task automatic t_wake();
    irq_en = 0; irq_unmask = 1; wake_en = 3'b001; sleep_active = 0;
    pin_in = 0; step();
    pin_in = 1; step();
    chk("R10 no wake awake", wake_sts, 1'b0);
    pin_in = 0; step();
    sleep_active = 1; pin_in = 1; step();
    chk("R10 wake set", wake_sts, 1'b1);
    chk("R10 no req while disabled", irq_req, 1'b0);
    irq_en = 1; #1;
    chk("R10 wake pending raises req", irq_req, 1'b1);
    irq_en = 0; wake_en = 3'b000; clear_all();
    chk("R8 wake clear", wake_sts, 1'b0);
    pin_in = 0; step();
    pin_in = 1; step();
    chk("R10 no wake without permission", wake_sts, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    step(); rst_n = 1; step();
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_disabled();
    t_mask();
    t_collision();
    t_wake();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule